// File: doc/BRIEF.md
# Debug Recovery Reset Sequencer

This block decides, around each power-on and warm reset, whether the core's level-1 data cache gets invalidated and whether the error-recording state gets cleared. The decision depends on the power mode held by the low-power handshake channel. The block issues one-cycle start pulses to an external cache invalidation engine and to the error-state logic. It waits for the engine's done strobe before it reports the core as running. It also arbitrates incoming mode requests.

A debug-recovery mode exists so that cache contents and error records written before a watchdog-triggered reset can still be read afterwards. The behaviour differs by how the mode is entered:

- If the channel holds debug-recovery while power-on reset is cycled, no invalidation is started.
- If the mode is requested later, it is accepted in the same cycle from any state, with no wait for the core to settle. A warm reset taken in this mode clears nothing.
- Leaving debug-recovery for the On mode starts no invalidation.

The block also supports an emulated-off mode. In this mode warm reset may be held externally. The mode stays reported and debug access stays open, while the functional side sees the core as off.

Top module: `dbgrec_seq`

## Requirements
- R1: Mode codes are 0 off, 1 emulated-off, 2 on and 3 debug-recovery. If the mode sampled during power-on reset is not 3, `invStart` and `errClear` are each high for exactly one cycle, in the cycle after the first clock edge that sees `porRstN` high.
- R2: If the mode sampled during power-on reset is 3, neither pulse appears after release. `curMode` reads 3 right after the first clock edge that sees `porRstN` high.
- R3: While an invalidation is pending, `curMode` reads 0. The held mode appears only after the clock edge that samples `invDone` high.
- R4: A request for mode 3 gives `reqAccept` high in the same cycle from any state after release, including while an invalidation is pending or warm reset is held. `curMode` reads 3 after the next edge, and any pending wait for `invDone` is dropped.
- R5: A request for any mode other than 3 is refused (`reqAccept` low, mode unchanged) while an invalidation is pending or `warmRstN` is low.
- R6: Releasing warm reset while the mode is 3 produces no `invStart` or `errClear` pulse, and the mode stays 3.
- R7: Releasing warm reset in any other mode produces one-cycle `invStart` and `errClear` pulses in the cycle after the edge that first sees `warmRstN` high again. `curMode` then reads 0 until done.
- R8: Moving from mode 3 to mode 2 by request produces no `invStart` pulse.
- R9: In mode 1 with warm reset held low, `curMode` keeps reading 1, `dbgAccess` stays high and `funcOff` stays high.
- R10: `funcOff` is low only when `curMode` is 2 and `warmRstN` is high. `dbgAccess` is high exactly when `curMode` is not 0.
- R11: While `porRstN` is low, after the first clock edge, `invStart`, `errClear`, `curMode` and `reqAccept` all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, sampled on the clock |
| warmRstN | input | 1 | Warm reset, active low |
| reqValid | input | 1 | Mode request present |
| reqMode | input | 2 | Requested mode; also the initial mode sampled during power-on reset |
| invDone | input | 1 | Done strobe from the cache invalidation engine |
| invStart | output | 1 | One-cycle pulse that starts a cache invalidation |
| errClear | output | 1 | One-cycle pulse that clears error-recording state |
| curMode | output | 2 | Reported power mode |
| reqAccept | output | 1 | Request accepted this cycle |
| funcOff | output | 1 | Functional interfaces see the core as off |
| dbgAccess | output | 1 | Debug registers accessible |

## Verification
A wrong phase or mode register inside the block reaches the ports as a missing or extra `invStart`/`errClear` pulse, or as `curMode` reading 0 or a stale mode one edge too early or too late. A behavioural model predicts every output on every cycle, so such a fault shows up at the first edge after it appears. Directed checks cover the cases where the two reset paths diverge:
- power-on reset with and without debug-recovery initialisation;
- warm reset in each mode;
- debug-recovery requests that arrive while an invalidation is still pending.

// File: rtl/dbgrec_pkg.sv
package dbgrec_pkg;
  localparam int ModeW = 2;

  typedef enum logic [ModeW-1:0] {
    PM_OFF    = 2'd0,
    PM_EMUOFF = 2'd1,
    PM_ON     = 2'd2,
    PM_DBGREC = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_WAIT  = 2'd1,
    PH_RUN   = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadInit;   // copy the mode sampled in reset into the mode register
    logic loadReq;    // copy the accepted request into the mode register
    logic fireClean;  // start invalidation and error clear
  } strobe_t;
endpackage

// File: rtl/dbgrec_ctrl.sv
module dbgrec_ctrl
  import dbgrec_pkg::*;
#(
  parameter int MW = ModeW
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          warmRstN,
  input  logic          reqValid,
  input  logic [MW-1:0] reqMode,
  input  logic          invDone,
  input  logic [MW-1:0] modeQ,
  input  logic [MW-1:0] initQ,
  output strobe_t       strb,
  output logic          reqAccept,
  output logic          busy,
  output logic          inRst
);
  phase_e        phaseQ, phaseD;
  logic          warmPrevQ;
  logic          dbgReq, warmRel, clean;
  logic [MW-1:0] nextMode;

  always_comb begin
    inRst     = (phaseQ == PH_RESET);
    busy      = (phaseQ == PH_WAIT);
    dbgReq    = reqValid && (reqMode == PM_DBGREC);
    reqAccept = reqValid && !inRst && (dbgReq || (!busy && warmRstN));
    nextMode  = reqAccept ? reqMode : modeQ;
    warmRel   = !warmPrevQ && warmRstN && !inRst;
    if (inRst) clean = (initQ != PM_DBGREC);
    else       clean = warmRel && (nextMode != PM_DBGREC);

    strb.loadInit  = inRst;
    strb.loadReq   = reqAccept;
    strb.fireClean = clean;

    phaseD = phaseQ;
    if (clean)                                       phaseD = PH_WAIT;
    else if (inRst)                                  phaseD = PH_RUN;
    else if (busy && ((reqAccept && dbgReq) || invDone)) phaseD = PH_RUN;
  end

  always_ff @(posedge clk) begin
    if (!porRstN) begin
      phaseQ    <= PH_RESET;
      warmPrevQ <= 1'b1;
    end else begin
      phaseQ    <= phaseD;
      warmPrevQ <= warmRstN;
    end
  end
endmodule

// File: rtl/dbgrec_dpath.sv
module dbgrec_dpath
  import dbgrec_pkg::*;
#(
  parameter int MW = ModeW
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          warmRstN,
  input  logic [MW-1:0] reqMode,
  input  strobe_t       strb,
  input  logic          busy,
  input  logic          inRst,
  output logic [MW-1:0] modeQ,
  output logic [MW-1:0] initQ,
  output logic          invStart,
  output logic          errClear,
  output logic [MW-1:0] curMode,
  output logic          funcOff,
  output logic          dbgAccess
);
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      initQ    <= reqMode;  // channel initial mode tracked through reset
      modeQ    <= PM_OFF;
      invStart <= 1'b0;
      errClear <= 1'b0;
    end else begin
      if (strb.loadInit)     modeQ <= initQ;
      else if (strb.loadReq) modeQ <= reqMode;
      invStart <= strb.fireClean;
      errClear <= strb.fireClean;
    end
  end

  always_comb begin
    curMode   = (inRst || busy) ? PM_OFF : modeQ;
    funcOff   = !((curMode == PM_ON) && warmRstN);
    dbgAccess = (curMode != PM_OFF);
  end
endmodule

// File: rtl/dbgrec_seq.sv
module dbgrec_seq
  import dbgrec_pkg::*;
#(
  parameter int MW = ModeW
) (
  input  logic          clk,
  input  logic          porRstN,
  input  logic          warmRstN,
  input  logic          reqValid,
  input  logic [MW-1:0] reqMode,
  input  logic          invDone,
  output logic          invStart,
  output logic          errClear,
  output logic [MW-1:0] curMode,
  output logic          reqAccept,
  output logic          funcOff,
  output logic          dbgAccess
);
  strobe_t       strb;
  logic          busy, inRst;
  logic [MW-1:0] modeQ, initQ;

  dbgrec_ctrl #(.MW(MW)) ctrl_i (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN), .reqValid(reqValid),
    .reqMode(reqMode), .invDone(invDone), .modeQ(modeQ), .initQ(initQ),
    .strb(strb), .reqAccept(reqAccept), .busy(busy), .inRst(inRst)
  );

  dbgrec_dpath #(.MW(MW)) dpath_i (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN), .reqMode(reqMode),
    .strb(strb), .busy(busy), .inRst(inRst), .modeQ(modeQ), .initQ(initQ),
    .invStart(invStart), .errClear(errClear), .curMode(curMode),
    .funcOff(funcOff), .dbgAccess(dbgAccess)
  );
endmodule

// File: rtl/dbgrec_chk.sv
module dbgrec_chk (
  input logic       clk,
  input logic       porRstN,
  input logic       warmRstN,
  input logic       reqValid,
  input logic [1:0] reqMode,
  input logic       invDone,
  input logic       invStart,
  input logic [1:0] curMode,
  input logic       reqAccept,
  input logic       inRst
);
  // R1
  inv_pulse_chk: assert property (@(posedge clk) disable iff (!porRstN)
    invStart |=> !invStart);

  // R4
  dbg_accept_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (reqValid && reqMode == 2'd3 && !inRst) |-> reqAccept);

  // R4
  dbg_mode_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (reqAccept && reqMode == 2'd3) |=> (curMode == 2'd3));

  // R5
  warm_refuse_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (reqValid && reqMode != 2'd3 && !warmRstN) |-> !reqAccept);

  // R3
  on_after_done_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(curMode == 2'd2) |-> ($past(invDone) || $past(reqAccept && reqMode == 2'd2)));

  // R6
  dbg_warm_keep_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (curMode == 2'd3 && !inRst && warmRstN && !$past(warmRstN) &&
     !(reqAccept && reqMode != 2'd3)) |=> !invStart);

  // R8
  dbg_to_on_chk: assert property (@(posedge clk) disable iff (!porRstN)
    ($past(curMode) == 2'd3 && curMode == 2'd2) |-> !invStart);
endmodule

bind dbgrec_seq dbgrec_chk chk_i (
  .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN), .reqValid(reqValid),
  .reqMode(reqMode), .invDone(invDone), .invStart(invStart),
  .curMode(curMode), .reqAccept(reqAccept), .inRst(inRst)
);

// File: tb/dbgrec_seq_tb.sv
`timescale 1ns/1ps
module dbgrec_seq_tb_top;
  logic       clk = 1'b0;
  logic       porRstN = 1'b0, warmRstN = 1'b1, reqValid = 1'b0, invDone = 1'b0;
  logic [1:0] reqMode = 2'd2;
  logic       invStart, errClear, reqAccept, funcOff, dbgAccess;
  logic [1:0] curMode;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dbgrec_seq dut_i (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN), .reqValid(reqValid),
    .reqMode(reqMode), .invDone(invDone), .invStart(invStart),
    .errClear(errClear), .curMode(curMode), .reqAccept(reqAccept),
    .funcOff(funcOff), .dbgAccess(dbgAccess)
  );

  // behavioural reference model
  int mMode = 0, mInit = 0;
  bit mPend = 0, mInReset = 1, mWarmLast = 1, mInv = 0, mErr = 0;

  function automatic bit modelAccept();
    if (!reqValid || mInReset) return 0;
    if (int'(reqMode) == 3) return 1;
    return !mPend && warmRstN;
  endfunction

  function automatic int modelCur();
    return (mInReset || mPend) ? 0 : mMode;
  endfunction

  always @(posedge clk) begin
    if (!porRstN) begin
      mInit = int'(reqMode); mMode = 0; mPend = 0; mInReset = 1;
      mWarmLast = 1; mInv = 0; mErr = 0;
    end else begin
      bit acc, wipe;
      int target;
      acc = modelAccept();
      target = acc ? int'(reqMode) : mMode;
      wipe = 0;
      if (mInReset) begin
        target = mInit;
        wipe = (mInit != 3);
      end else if (!mWarmLast && warmRstN && target != 3) begin
        wipe = 1;
      end
      if (wipe) mPend = 1;
      else if ((acc && int'(reqMode) == 3) || invDone) mPend = 0;
      mInv = wipe; mErr = wipe; mMode = target;
      mInReset = 0; mWarmLast = warmRstN;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare, 1 ns after each edge
  always begin
    @(posedge clk);
    #1;
    if (!finished) begin
      chk("R1/R7 invStart", int'(invStart), int'(mInv));
      chk("R7 errClear", int'(errClear), int'(mErr));
      chk("R3 curMode", int'(curMode), modelCur());
      chk("R4/R5 reqAccept", int'(reqAccept), int'(modelAccept()));
      chk("R10 funcOff", int'(funcOff), int'(!(modelCur() == 2 && warmRstN)));
      chk("R10 dbgAccess", int'(dbgAccess), int'(modelCur() != 0));
    end
  end

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(8 * 5000);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    // R11 reset state, first power-on with init mode 2
    reqValid = 1; reqMode = 2'd2;
    cyc(3);
    chk("R11 curMode", int'(curMode), 0);
    chk("R11 reqAccept", int'(reqAccept), 0);
    chk("R11 invStart", int'(invStart), 0);
    reqValid = 0;
    porRstN = 1;
    cyc();
    chk("R1 invStart", int'(invStart), 1);
    chk("R1 errClear", int'(errClear), 1);
    chk("R3 pending curMode", int'(curMode), 0);
    cyc();
    chk("R1 single pulse", int'(invStart), 0);
    invDone = 1; cyc(); invDone = 0;
    chk("R3 on after done", int'(curMode), 2);

    // go to emulated-off, then hold warm reset
    reqValid = 1; reqMode = 2'd1; #1;
    chk("R5 accept when idle", int'(reqAccept), 1);
    cyc(); reqValid = 0;
    chk("R10 funcOff emu", int'(funcOff), 1);
    warmRstN = 0;
    cyc(3);
    chk("R9 curMode", int'(curMode), 1);
    chk("R9 dbgAccess", int'(dbgAccess), 1);
    chk("R9 funcOff", int'(funcOff), 1);
    reqValid = 1; reqMode = 2'd2; #1;
    chk("R5 refuse in warm", int'(reqAccept), 0);
    cyc(); reqValid = 0;
    chk("R5 mode kept", int'(curMode), 1);
    warmRstN = 1;
    cyc();
    chk("R7 invStart", int'(invStart), 1);
    chk("R7 errClear", int'(errClear), 1);
    chk("R7 curMode", int'(curMode), 0);
    reqValid = 1; reqMode = 2'd2; #1;
    chk("R5 refuse busy", int'(reqAccept), 0);
    reqMode = 2'd3; #1;
    chk("R4 accept busy", int'(reqAccept), 1);
    cyc(); reqValid = 0;
    chk("R4 mode", int'(curMode), 3);
    invDone = 1; cyc(); invDone = 0;
    chk("R4 late done ignored", int'(curMode), 3);

    // warm reset in debug-recovery
    warmRstN = 0; cyc(2);
    warmRstN = 1; cyc();
    chk("R6 invStart", int'(invStart), 0);
    chk("R6 errClear", int'(errClear), 0);
    cyc();
    chk("R6 mode", int'(curMode), 3);

    // debug-recovery to on
    reqValid = 1; reqMode = 2'd2;
    cyc(); reqValid = 0;
    chk("R8 mode", int'(curMode), 2);
    chk("R8 invStart", int'(invStart), 0);
    cyc();
    chk("R8 invStart later", int'(invStart), 0);
    chk("R10 funcOff on", int'(funcOff), 0);

    // warm reset in on
    warmRstN = 0; cyc();
    chk("R10 funcOff warm", int'(funcOff), 1);
    warmRstN = 1; cyc();
    chk("R7 on invStart", int'(invStart), 1);
    cyc(2);
    invDone = 1; cyc(); invDone = 0;
    chk("R3 on again", int'(curMode), 2);

    reqValid = 1; reqMode = 2'd0;
    cyc(); reqValid = 0;
    chk("R10 dbgAccess off", int'(dbgAccess), 0);

    // power-on with debug-recovery initialisation
    porRstN = 0; reqMode = 2'd3;
    cyc(3);
    porRstN = 1; cyc();
    chk("R2 invStart", int'(invStart), 0);
    chk("R2 errClear", int'(errClear), 0);
    chk("R2 curMode", int'(curMode), 3);
    cyc();
    chk("R2 invStart later", int'(invStart), 0);

    // power-on with emulated-off initialisation
    porRstN = 0; reqMode = 2'd1;
    cyc(2);
    porRstN = 1; cyc();
    chk("R1 emu invStart", int'(invStart), 1);
    invDone = 1; cyc(); invDone = 0;
    chk("R3 emu mode", int'(curMode), 1);
    cyc(3);
    finishRun();
  end
endmodule